// File: doc/BRIEF.md
# Multiplexed Host Bus Cycle Decoder

This block is the host-side front end of a slave port. Through it an external processor reaches local memory over one shared address/data bus. A static mode input selects a 32-bit bus or a 16-bit bus. In 16-bit mode, every 32-bit quantity moves as a pair of halfwords, and a halfword-select pin marks which half is on the bus.

The block builds one internal strobe from chip select and two data strobes. It captures the access kind, direction, halfword select and address select. Each access is then steered to one of three places:
- a configuration register;
- a pair of 32-bit address registers (read and write), which act as one register or as two;
- the data path, which receives one write pulse per complete word and issues one read request per word.

The FIFOs, the memory-side transfer engine and the interrupt logic sit outside this block. They use the write pulse, the read request and the read response ports.

Top module: `hbus_cycle_decoder`

## Requirements
- R1: After reset, the configuration register, both address registers and `hd_out` are zero, and neither `wr_valid` nor `rd_req` has pulsed.
- R2: The internal strobe is active only while `cs_n` is low and `ds_a` differs from `ds_b`. With `cs_n` high, or with both data strobes at the same level, no register changes and no pulse is issued.
- R3: When `ale_n` falls, the kind, direction, halfword-select and address-select pins are captured, and later changes on those pins before the strobe do not alter the access. When `ale_n` stays high, the same pins are captured when the strobe becomes active.
- R4: The access kind is coded as follows: 2'b00 is the configuration register, 2'b01 is data with address autoincrement, 2'b10 is the address register, and 2'b11 is data without autoincrement. `rnw` = 1 means a host read.
- R5: In 16-bit mode (`wide` = 0), `hw_sel` = 0 carries the low half and `hw_sel` = 1 carries the high half of an address or data word. `wr_valid` pulses once, for one cycle, only after the high half ends, and carries the combined word.
- R6: In 16-bit mode, one halfword write to the configuration register loads its 16 bits into both halves of `cfg`. A configuration read returns `cfg[15:0]` on `hd_out[15:0]`.
- R7: With `cfg[0]` = 0 (single mode), a completed address write loads both address registers. An address read returns the write address register. In single mode, an autoincrement advances both registers.
- R8: With `cfg[0]` = 1 (dual mode), `asel` = 0 selects the write address register and `asel` = 1 selects the read address register, for both address writes and address reads. In dual mode, an autoincrement advances only the register of the access direction.
- R9: A kind 2'b01 data access advances the used address by 4 after its word completes. Kind 2'b11 leaves the address unchanged.
- R10: A data read issues one `rd_req` pulse carrying the read address, when the strobe of the first (or only) halfword becomes active. The response word is then presented on `hd_out`: whole in 32-bit mode, or as the half named by `hw_sel` on `hd_out[15:0]` in 16-bit mode.
- R11: An address read returns the selected address register on `hd_out`, whole or as the half named by `hw_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide | input | 1 | Static bus mode: 1 = 32-bit, 0 = 16-bit halfword pairs |
| cs_n | input | 1 | Chip select, active low |
| ds_a | input | 1 | First data strobe |
| ds_b | input | 1 | Second data strobe |
| ale_n | input | 1 | Address-latch strobe; falling edge captures the cycle pins |
| acc_kind | input | 2 | Access kind code |
| rnw | input | 1 | 1 = host read, 0 = host write |
| hw_sel | input | 1 | Halfword select in 16-bit mode (0 = low half) |
| asel | input | 1 | Address register select in dual mode (1 = read register) |
| hd_in | input | DW | Bus value driven by the host |
| hd_out | output | DW | Registered read value returned to the host |
| cfg | output | DW | Configuration register; bit 0 enables dual address mode |
| wr_valid | output | 1 | One-cycle pulse: a complete data word is ready |
| wr_addr | output | DW | Address for the write word |
| wr_data | output | DW | Write word |
| rd_req | output | 1 | One-cycle pulse: fetch a word |
| rd_addr | output | DW | Address for the fetch |
| rd_rsp_valid | input | 1 | Fetched word is present |
| rd_rsp_data | input | DW | Fetched word |

## Verification
Pins pass through one capture register. A strobe release therefore produces `wr_valid`, the new address value and the new `cfg` two clock edges later. `rd_req` rises two edges after the strobe becomes active. `hd_out` follows the latched access one edge after that, and for data reads one edge after the response arrives. The bench holds every strobe for six cycles and reads `hd_out` just before releasing it. It waits four cycles after the release before comparing pulses and register effects. All comparisons are made on falling edges, so each result is checked well after its due edge and before the next access starts.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {
    K_CTRL = 2'b00,
    K_DINC = 2'b01,
    K_ADDR = 2'b10,
    K_DATA = 2'b11
  } kind_e;

  typedef struct packed {
    kind_e kind;
    logic  rnw;
    logic  hw;
    logic  asel;
  } cyc_t;
endpackage

// File: rtl/hb_front.sv
module hb_front
  import hb_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          ds_a,
  input  logic          ds_b,
  input  logic          ale_n,
  input  logic [1:0]    acc_kind,
  input  logic          rnw,
  input  logic          hw_sel,
  input  logic          asel,
  input  logic [DW-1:0] hd_in,
  output logic          stb,
  output logic          start,
  output logic          stop,
  output cyc_t          now,
  output cyc_t          held,
  output logic [DW-1:0] hd_cap
);
  logic p_cs_n, p_ds_a, p_ds_b, p_ale_n, ale_q, stb_q, pend;
  cyc_t pin_c;
  logic [DW-1:0] p_hd;
  logic ale_fall;

  // capture stage for all host pins
  always_ff @(posedge clk) begin
    if (rst) begin
      p_cs_n  <= 1'b1;
      p_ds_a  <= 1'b0;
      p_ds_b  <= 1'b0;
      p_ale_n <= 1'b1;
      ale_q   <= 1'b1;
      stb_q   <= 1'b0;
      pin_c   <= '{kind: K_CTRL, rnw: 1'b0, hw: 1'b0, asel: 1'b0};
      p_hd    <= '0;
    end else begin
      p_cs_n  <= cs_n;
      p_ds_a  <= ds_a;
      p_ds_b  <= ds_b;
      p_ale_n <= ale_n;
      ale_q   <= p_ale_n;
      stb_q   <= stb;
      pin_c   <= '{kind: kind_e'(acc_kind), rnw: rnw, hw: hw_sel, asel: asel};
      p_hd    <= hd_in;
    end
  end

  assign stb      = ~p_cs_n & (p_ds_a ^ p_ds_b);
  assign start    = stb & ~stb_q;
  assign stop     = ~stb & stb_q;
  assign ale_fall = ale_q & ~p_ale_n;
  assign now      = pend ? held : pin_c;

  // cycle descriptor latch: address-latch edge first, strobe edge otherwise
  always_ff @(posedge clk) begin
    if (rst) begin
      held <= '{kind: K_CTRL, rnw: 1'b0, hw: 1'b0, asel: 1'b0};
      pend <= 1'b0;
    end else if (ale_fall) begin
      held <= pin_c;
      pend <= 1'b1;
    end else begin
      if (start && !pend) held <= pin_c;
      if (stop) pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      hd_cap <= '0;
    else if (stb) hd_cap <= p_hd;
  end
endmodule

// File: rtl/hb_core.sv
module hb_core
  import hb_pkg::*;
#(
  parameter int DW       = 32,
  parameter int STEP     = 4,
  parameter int DUAL_BIT = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wide,
  input  logic          stb,
  input  logic          start,
  input  logic          stop,
  input  kind_e         now_kind,
  input  logic          now_rnw,
  input  logic          now_hw,
  input  cyc_t          lt,
  input  logic [DW-1:0] hd_cap,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  output logic [DW-1:0] cfg,
  output logic [DW-1:0] hd_out,
  output logic          wr_valid,
  output logic [DW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          rd_req,
  output logic [DW-1:0] rd_addr
);
  localparam int HW   = DW / 2;
  localparam int NREG = 2;
  localparam int WSEL = 0;
  localparam int RSEL = 1;

  function automatic logic is_data(kind_e k);
    return (k == K_DINC) || (k == K_DATA);
  endfunction

  logic [DW-1:0] areg [NREG];
  logic [NREG-1:0] ld, inc;
  logic [HW-1:0] lo;
  logic [DW-1:0] word, rd_hold, src, sel;
  logic dual, last, first_now, wr_stop;

  assign dual      = cfg[DUAL_BIT];
  assign last      = wide | lt.hw;
  assign first_now = wide | ~now_hw;
  assign wr_stop   = stop & ~lt.rnw;
  assign word      = wide ? hd_cap : {hd_cap[HW-1:0], lo};

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      ld[i]  = wr_stop && (lt.kind == K_ADDR) && last &&
               (!dual || (lt.asel == (i == RSEL)));
      inc[i] = stop && (lt.kind == K_DINC) && last &&
               (!dual || (lt.rnw == (i == RSEL)));
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (rst)         areg[i] <= '0;
      else if (ld[i])  areg[i] <= word;
      else if (inc[i]) areg[i] <= areg[i] + DW'(STEP);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg      <= '0;
      lo       <= '0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      rd_req   <= 1'b0;
      rd_addr  <= '0;
      rd_hold  <= '0;
    end else begin
      if (wr_stop && lt.kind == K_CTRL)
        cfg <= wide ? hd_cap : {hd_cap[HW-1:0], hd_cap[HW-1:0]};
      if (wr_stop && lt.kind != K_CTRL && !last)
        lo <= hd_cap[HW-1:0];
      wr_valid <= wr_stop && is_data(lt.kind) && last;
      wr_data  <= word;
      wr_addr  <= areg[WSEL];
      rd_req   <= start && now_rnw && is_data(now_kind) && first_now;
      rd_addr  <= areg[RSEL];
      if (rsp_valid) rd_hold <= rsp_data;
    end
  end

  // read value: whole word, or the addressed half on the low lane
  always_comb begin
    case (lt.kind)
      K_CTRL:  src = cfg;
      K_ADDR:  src = (dual && lt.asel) ? areg[RSEL] : areg[WSEL];
      default: src = rd_hold;
    endcase
    if (wide)       sel = src;
    else if (lt.hw) sel = {{HW{1'b0}}, src[DW-1:HW]};
    else            sel = {{HW{1'b0}}, src[HW-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst)                hd_out <= '0;
    else if (stb && lt.rnw) hd_out <= sel;
  end
endmodule

// File: rtl/hbus_cycle_decoder.sv
module hbus_cycle_decoder
  import hb_pkg::*;
#(
  parameter int DW   = 32,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wide,
  input  logic          cs_n,
  input  logic          ds_a,
  input  logic          ds_b,
  input  logic          ale_n,
  input  logic [1:0]    acc_kind,
  input  logic          rnw,
  input  logic          hw_sel,
  input  logic          asel,
  input  logic [DW-1:0] hd_in,
  output logic [DW-1:0] hd_out,
  output logic [DW-1:0] cfg,
  output logic          wr_valid,
  output logic [DW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          rd_req,
  output logic [DW-1:0] rd_addr,
  input  logic          rd_rsp_valid,
  input  logic [DW-1:0] rd_rsp_data
);
  logic f_stb, f_start, f_stop, held_hw;
  cyc_t f_now, f_held;
  logic [DW-1:0] f_hd;

  hb_front #(.DW(DW)) u_front (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ds_a(ds_a), .ds_b(ds_b),
    .ale_n(ale_n), .acc_kind(acc_kind), .rnw(rnw), .hw_sel(hw_sel),
    .asel(asel), .hd_in(hd_in), .stb(f_stb), .start(f_start),
    .stop(f_stop), .now(f_now), .held(f_held), .hd_cap(f_hd)
  );

  hb_core #(.DW(DW), .STEP(STEP), .DUAL_BIT(0)) u_core (
    .clk(clk), .rst(rst), .wide(wide), .stb(f_stb), .start(f_start),
    .stop(f_stop), .now_kind(f_now.kind), .now_rnw(f_now.rnw),
    .now_hw(f_now.hw), .lt(f_held), .hd_cap(f_hd),
    .rsp_valid(rd_rsp_valid), .rsp_data(rd_rsp_data), .cfg(cfg),
    .hd_out(hd_out), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_req(rd_req), .rd_addr(rd_addr)
  );

  assign held_hw = f_held.hw;
endmodule

// File: rtl/hbus_cycle_decoder_chk.sv
module hbus_cycle_decoder_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          wide,
  input logic [DW-1:0] cfg,
  input logic          wr_valid,
  input logic          rd_req,
  input logic          f_start,
  input logic          f_stop,
  input logic          held_hw
);
  localparam int HW = DW / 2;

  // R2
  wr_after_release_chk: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> $past(f_stop));

  // R10
  req_after_assert_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> $past(f_start));

  // R5
  wr_high_half_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wide) |-> $past(held_hw));

  // R5
  wr_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> !wr_valid);

  // R6
  cfg_mirror_chk: assert property (@(posedge clk) disable iff (rst)
    !wide |-> (cfg[DW-1:HW] == cfg[HW-1:0]));

  // R10
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_valid, rd_req}));
endmodule

bind hbus_cycle_decoder hbus_cycle_decoder_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .wide(wide), .cfg(cfg), .wr_valid(wr_valid),
  .rd_req(rd_req), .f_start(f_start), .f_stop(f_stop), .held_hw(held_hw)
);

// File: tb/sim_hbus_cycle_decoder.sv
module sim_hbus_cycle_decoder;
  logic clk = 1'b0, rst = 1'b1, wide = 1'b0;
  logic cs_n = 1'b1, ds_a = 1'b0, ds_b = 1'b0, ale_n = 1'b1;
  logic [1:0] acc_kind = 2'b00;
  logic rnw = 1'b0, hw_sel = 1'b0, asel = 1'b0;
  logic [31:0] hd_in = '0, hd_out, cfg, wr_addr, wr_data, rd_addr;
  logic wr_valid, rd_req, rsp_v = 1'b0;
  logic [31:0] rsp_d = '0;

  int nchk = 0, nfail = 0, wr_cnt = 0, rd_cnt = 0;
  logic [31:0] wr_last_a, wr_last_d, rd_last_a;
  logic [31:0] cfg_m, aw_m, ar_m, held_m;
  logic [15:0] lo_m;
  bit done = 0;

  always #5 clk = ~clk;

  hbus_cycle_decoder u0 (
    .clk(clk), .rst(rst), .wide(wide), .cs_n(cs_n), .ds_a(ds_a),
    .ds_b(ds_b), .ale_n(ale_n), .acc_kind(acc_kind), .rnw(rnw),
    .hw_sel(hw_sel), .asel(asel), .hd_in(hd_in), .hd_out(hd_out),
    .cfg(cfg), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_rsp_valid(rsp_v),
    .rd_rsp_data(rsp_d)
  );

  function automatic logic [31:0] memw(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // data-path model: answers fetches, records pulses
  initial forever begin
    @(negedge clk);
    rsp_v = 1'b0;
    if (rd_req) begin
      rsp_v = 1'b1; rsp_d = memw(rd_addr); rd_cnt++; rd_last_a = rd_addr;
    end
    if (wr_valid) begin
      wr_cnt++; wr_last_a = wr_addr; wr_last_d = wr_data;
    end
  end

  task automatic do_reset(input bit w);
    @(negedge clk);
    rst = 1'b1; wide = w;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cfg_m = '0; aw_m = '0; ar_m = '0; lo_m = '0; held_m = '0;
    @(negedge clk);
    // R1 reset state
    chk(cfg == 32'h0, "R1", cfg, 32'h0);
    chk(hd_out == 32'h0, "R1", hd_out, 32'h0);
    chk(!wr_valid && !rd_req, "R1", {wr_valid, rd_req}, 32'h0);
  endtask

  task automatic access(input logic [1:0] k, input bit r, input bit h,
                        input bit s, input logic [31:0] din, input bit ale,
                        input bit alt);
    logic [31:0] exp_hd, v, a;
    bit dual, last, first;
    int wc0, rc0;
    dual = cfg_m[0]; last = wide || h; first = wide || !h;
    if (k == 2'b00) begin last = 1'b1; first = 1'b1; end
    wc0 = wr_cnt; rc0 = rd_cnt;
    v = wide ? din : {din[15:0], lo_m};
    exp_hd = '0;
    if (r) begin
      if (k == 2'b00) a = cfg_m;
      else if (k == 2'b10) a = (dual && s) ? ar_m : aw_m;
      else begin
        if (first) held_m = memw(ar_m);
        a = held_m;
      end
      exp_hd = wide ? a : (h && k != 2'b00) ? {16'h0, a[31:16]} : {16'h0, a[15:0]};
    end
    @(negedge clk);
    cs_n = 1'b0; acc_kind = k; rnw = r; hw_sel = h; asel = s; hd_in = din;
    if (ale) begin
      ale_n = 1'b0;
      @(negedge clk);
      // R3 pins move after the address-latch edge
      acc_kind = ~k; rnw = ~r; hw_sel = ~h; asel = ~s; ale_n = 1'b1;
    end
    if (alt) ds_b = 1'b1; else ds_a = 1'b1;
    repeat (6) @(negedge clk);
    if (r) chk(hd_out == exp_hd, (k == 2'b10) ? "R11" : (k == 2'b00) ? "R6" : "R10",
               hd_out, exp_hd);
    ds_a = 1'b0; ds_b = 1'b0;
    @(negedge clk);
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
    if (r) begin
      if ((k == 2'b01 || k == 2'b11) && first) begin
        chk(rd_cnt == rc0 + 1, "R10", rd_cnt, rc0 + 1);
        chk(rd_last_a == ar_m, "R9", rd_last_a, ar_m);
      end else chk(rd_cnt == rc0, "R10", rd_cnt, rc0);
      if (k == 2'b01 && last) begin
        ar_m += 4; if (!dual) aw_m += 4;
      end
    end else begin
      case (k)
        2'b00: begin
          cfg_m = wide ? din : {din[15:0], din[15:0]};
          chk(cfg == cfg_m, "R6", cfg, cfg_m);
        end
        2'b10: begin
          if (!last) lo_m = din[15:0];
          else if (!dual) begin aw_m = v; ar_m = v; end
          else if (s) ar_m = v;
          else aw_m = v;
        end
        default: begin
          if (!last) begin
            lo_m = din[15:0];
            chk(wr_cnt == wc0, "R5", wr_cnt, wc0);
          end else begin
            chk(wr_cnt == wc0 + 1, "R5", wr_cnt, wc0 + 1);
            chk(wr_last_d == v, "R5", wr_last_d, v);
            chk(wr_last_a == aw_m, "R7", wr_last_a, aw_m);
            if (k == 2'b01) begin aw_m += 4; if (!dual) ar_m += 4; end
          end
        end
      endcase
    end
  endtask

  // one logical operation: a halfword pair in 16-bit mode where needed
  task automatic op(input logic [1:0] k, input bit r, input bit s,
                    input logic [31:0] d, input bit ale, input bit alt);
    if (wide || k == 2'b00) access(k, r, 1'b0, s, d, ale, alt);
    else begin
      access(k, r, 1'b0, s, {16'h0, d[15:0]}, ale, alt);
      access(k, r, 1'b1, s, {16'h0, d[31:16]}, ale, !alt);
    end
  endtask

  task automatic bogus(input bit cs, input bit a, input bit b, input logic [1:0] k);
    int wc0;
    wc0 = wr_cnt;
    @(negedge clk);
    cs_n = cs; acc_kind = k; rnw = 1'b0; hw_sel = 1'b1; hd_in = ~cfg_m;
    ds_a = a; ds_b = b;
    repeat (6) @(negedge clk);
    ds_a = 1'b0; ds_b = 1'b0; cs_n = 1'b1;
    repeat (4) @(negedge clk);
    // R2 no strobe, no effect
    chk(cfg == cfg_m, "R2", cfg, cfg_m);
    chk(wr_cnt == wc0, "R2", wr_cnt, wc0);
  endtask

  task automatic rand_run(input int n);
    for (int i = 0; i < n; i++) begin
      int sel;
      logic [31:0] d;
      bit ale, alt, s;
      sel = $urandom % 8; d = $urandom;
      ale = $urandom % 2; alt = $urandom % 2; s = $urandom % 2;
      case (sel)
        0:       op(2'b00, 1'b0, s, d, ale, alt);
        1:       op(2'b00, 1'b1, s, d, ale, alt);
        2:       op(2'b10, 1'b0, s, d, ale, alt);
        3:       op(2'b10, 1'b1, s, d, ale, alt);
        4, 5:    op(($urandom % 2) ? 2'b01 : 2'b11, 1'b0, s, d, ale, alt);
        default: op(($urandom % 2) ? 2'b01 : 2'b11, 1'b1, s, d, ale, alt);
      endcase
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // 16-bit phase
    do_reset(1'b0);
    op(2'b10, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0);           // R1 address reads zero
    op(2'b00, 1'b0, 1'b0, 32'h0000ABCC, 1'b0, 1'b0);    // R6 mirror, single mode
    op(2'b10, 1'b0, 1'b0, 32'h1234_5670, 1'b1, 1'b0);   // R3 R7 via address latch
    op(2'b10, 1'b1, 1'b0, 32'h0, 1'b0, 1'b1);           // R11 halves
    op(2'b01, 1'b0, 1'b0, 32'hCAFE_F00D, 1'b0, 1'b0);   // R5 R9 pair
    op(2'b11, 1'b1, 1'b0, 32'h0, 1'b1, 1'b0);           // R10 no increment
    op(2'b01, 1'b1, 1'b0, 32'h0, 1'b0, 1'b1);           // R9 R10
    rand_run(150);
    // 32-bit phase
    do_reset(1'b1);
    bogus(1'b0, 1'b1, 1'b1, 2'b00);                     // R2 both strobes active
    bogus(1'b1, 1'b1, 1'b0, 2'b11);                     // R2 chip select high
    op(2'b00, 1'b0, 1'b0, 32'h0000_0001, 1'b0, 1'b0);   // R8 dual mode on
    op(2'b10, 1'b0, 1'b0, 32'h0000_1000, 1'b0, 1'b0);
    op(2'b10, 1'b0, 1'b1, 32'h0000_2000, 1'b1, 1'b0);
    op(2'b10, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0);           // R8 R11
    op(2'b10, 1'b1, 1'b1, 32'h0, 1'b0, 1'b1);
    op(2'b01, 1'b0, 1'b0, 32'h1111_2222, 1'b0, 1'b0);   // R8 R9 write side only
    op(2'b01, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0);           // R8 read side
    op(2'b11, 1'b0, 1'b0, 32'h3333_4444, 1'b1, 1'b1);   // R9 no increment
    op(2'b11, 1'b0, 1'b0, 32'h5555_6666, 1'b0, 1'b0);
    op(2'b10, 1'b1, 1'b1, 32'h0, 1'b0, 1'b0);           // R4 R8
    rand_run(150);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule